// File: doc/BRIEF.md
# Masked Fault Latch and Interrupt Controller

This block watches six power-good inputs and two fault flags, one for undervoltage and one for overtemperature. It passes all of them through a two-flop synchronizer. From the synchronized values it builds a real-time status byte and a latched status byte. Software reads both bytes through the surrounding register interface.

The block drives two active-low outputs, each meant to pull down an open-drain pin:

- **Reset line.** It follows the faults that are present now, gated by the reset mask. It never latches.
- **Interrupt line.** It follows the latched faults, gated by the interrupt mask.

After reset the reset mask is all ones and the interrupt mask is all zeros. So by default every fault reaches the reset pin and none reaches the interrupt pin. Software changes a mask by pulsing its write strobe with the new byte on the shared write-data bus.

A one-cycle clear pulse empties the latched byte and releases the interrupt. If a fault is still present, it latches again one cycle later.

The interrupt line is driven by a two-state machine:

- **IRQ_QUIET**: the pin is released (high).
- **IRQ_FLAGGED**: the pin is pulled low.

Its two transitions are:

- **QUIET to FLAGGED** (raise): taken when a latched bit is unmasked and no clear is present.
- **FLAGGED to QUIET** (release): taken on a clear, or when no latched bit remains unmasked.

Top module: `pwr_fault_ctl`

## Requirements
- R1: `rt_status[5:0]` shows the six synchronized power-good inputs (1 = good), and `rt_status[7:6]` read 0. An input change shows in `rt_status` after two rising clock edges.
- R2: `lat_status` uses one fault bit per position, with 1 meaning the fault was seen. Bit 7 is undervoltage (`uv_in` high). Bit 6 is overtemperature (`ot_in` high). Bit k, for k from 0 to 5, is power-good k lost (`pg_in[k]` low).
- R3: A set bit of `lat_status` stays set after its fault goes away, until a clear pulse.
- R4: A clear pulse (`clr_pulse` high for one cycle) makes `lat_status` zero on the following cycle. A fault that is still present sets its bit again one cycle after that.
- R5: `rst_out_n` is low exactly while a present fault has its reset-mask bit set. The reset mask uses the bit positions of R2. It goes high again when the fault ends, with no clear needed.
- R6: After reset the reset mask is 8'hFF, so any single fault pulls `rst_out_n` low.
- R7: `irq_n` is low while any `lat_status` bit has its interrupt-mask bit set. The interrupt mask uses the bit positions of R2. A clear releases it, and it goes low again if the fault re-latches.
- R8: After reset the interrupt mask is 8'h00, so faults leave `irq_n` high.
- R9: When `rmask_we` is high at a rising edge, the reset mask takes `mask_wdata`. When `imask_we` is high at a rising edge, the interrupt mask takes `mask_wdata`.
- R10: After reset, `lat_status` is 0, `irq_n` and `rst_out_n` are 1, and `rt_status` is 8'h3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_in | input | 6 | Power-good inputs, 1 = good |
| uv_in | input | 1 | Undervoltage flag, 1 = fault |
| ot_in | input | 1 | Overtemperature flag, 1 = fault |
| clr_pulse | input | 1 | One-cycle clear of latched status and interrupt |
| rmask_we | input | 1 | Load reset mask from mask_wdata |
| imask_we | input | 1 | Load interrupt mask from mask_wdata |
| mask_wdata | input | 8 | Mask write data, bit positions as lat_status |
| rt_status | output | 8 | Real-time status byte |
| lat_status | output | 8 | Latched fault status byte |
| irq_n | output | 1 | Active-low interrupt line |
| rst_out_n | output | 1 | Active-low reset line |

## Verification
Directed cases exercise the default masks, the reset state, and the re-latch after a clear. Together they separate the two pins: the reset line falls on a fault that the interrupt ignores. They also separate the two masks: each mask routes a fault to one pin only.

Random input patterns with random mask writes and random clears are compared against a bench model of the latched byte. Single faults, multiple faults and faults that disappear before a clear show the sticky latch apart from the real-time view. The check that a bit is still held after its fault goes away shows that only a clear can empty the latch.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int N_PG   = 6;
    localparam int STAT_W = N_PG + 2;
    localparam int UV_BIT = STAT_W - 1;
    localparam int OT_BIT = STAT_W - 2;

    typedef enum logic [0:0] {
        IRQ_QUIET   = 1'b0,
        IRQ_FLAGGED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
    parameter int         W       = 8,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[s] <= RST_VAL;
                    else        stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[s] <= RST_VAL;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pfc_latch.sv
module pfc_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] fault_now,
    input  logic         clr,
    output logic [W-1:0] lat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   lat <= '0;
        else if (clr) lat <= '0;
        else          lat <= lat | fault_now;
    end

    // R3
    sticky_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((lat & $past(lat)) == $past(lat)));

    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lat == '0));
endmodule

// File: rtl/pfc_irq_fsm.sv
module pfc_irq_fsm
    import pfc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lat,
    input  logic [W-1:0] imask,
    input  logic         clr,
    output logic         irq_n
);
    irq_state_t state, state_nx;
    logic       pending;

    assign pending = |(lat & imask);

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_QUIET:   if (pending && !clr) state_nx = IRQ_FLAGGED;
            IRQ_FLAGGED: if (clr || !pending) state_nx = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        irq_n = (state != IRQ_FLAGGED);
    end

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> !irq_n);

    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> irq_n);
endmodule

// File: rtl/pwr_fault_ctl.sv
module pwr_fault_ctl
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PG-1:0]   pg_in,
    input  logic              uv_in,
    input  logic              ot_in,
    input  logic              clr_pulse,
    input  logic              rmask_we,
    input  logic              imask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] rt_status,
    output logic [STAT_W-1:0] lat_status,
    output logic              irq_n,
    output logic              rst_out_n
);
    localparam logic [STAT_W-1:0] SYNC_RST = {2'b00, {N_PG{1'b1}}};

    logic [STAT_W-1:0] raw_in, sync_q, fault_now;
    logic [STAT_W-1:0] rmask_q, imask_q;

    assign raw_in = {uv_in, ot_in, pg_in};

    pfc_sync #(.W(STAT_W), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
    );

    assign fault_now = {sync_q[UV_BIT], sync_q[OT_BIT], ~sync_q[N_PG-1:0]};
    assign rt_status = {2'b00, sync_q[N_PG-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rmask_q <= '1;
            imask_q <= '0;
        end else begin
            if (rmask_we) rmask_q <= mask_wdata;
            if (imask_we) imask_q <= mask_wdata;
        end
    end

    pfc_latch #(.W(STAT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .fault_now(fault_now),
        .clr(clr_pulse), .lat(lat_status)
    );

    pfc_irq_fsm #(.W(STAT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .lat(lat_status), .imask(imask_q),
        .clr(clr_pulse), .irq_n(irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_out_n <= 1'b1;
        else        rst_out_n <= ~|(fault_now & rmask_q);
    end

    // R5
    rst_follows_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fault_now & rmask_q)) |=> !rst_out_n);

    // R5
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(fault_now & rmask_q)) |=> rst_out_n);

    // R2
    latch_catches_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_pulse |=> ((lat_status & $past(fault_now)) == $past(fault_now)));
endmodule

// File: tb/pwr_fault_ctl_bench.sv
module pwr_fault_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pg_in = 6'h3F;
    logic       uv_in = 1'b0, ot_in = 1'b0;
    logic       clr_pulse = 1'b0, rmask_we = 1'b0, imask_we = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic [7:0] rt_status, lat_status;
    logic       irq_n, rst_out_n;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_rmask, m_imask, m_lat;
    int unsigned seed = 32'd12345;

    always #2.5 clk = ~clk;

    pwr_fault_ctl u_pwr_fault_ctl (
        .clk(clk), .rst_n(rst_n), .pg_in(pg_in), .uv_in(uv_in), .ot_in(ot_in),
        .clr_pulse(clr_pulse), .rmask_we(rmask_we), .imask_we(imask_we),
        .mask_wdata(mask_wdata), .rt_status(rt_status), .lat_status(lat_status),
        .irq_n(irq_n), .rst_out_n(rst_out_n)
    );

    function automatic logic [7:0] fault_of(logic [5:0] pg, logic uv, logic ot);
        return {uv, ot, ~pg};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(logic [5:0] pg, logic uv, logic ot);
        @(negedge clk);
        pg_in = pg; uv_in = uv; ot_in = ot;
        settle();
        m_lat = m_lat | fault_of(pg, uv, ot);
    endtask

    task automatic check_all(string tag);
        logic [7:0] f;
        f = fault_of(pg_in, uv_in, ot_in);
        chk({tag, " R1 rt_status"}, rt_status, {2'b00, pg_in});
        chk({tag, " R2 lat_status"}, lat_status, m_lat);
        chk({tag, " R5 rst_out_n"}, {7'b0, rst_out_n}, {7'b0, ~|(f & m_rmask)});
        chk({tag, " R7 irq_n"}, {7'b0, irq_n}, {7'b0, ~|(m_lat & m_imask)});
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_pulse = 1'b1;
        @(negedge clk);
        clr_pulse = 1'b0;
    endtask

    task automatic write_mask(logic which_irq, logic [7:0] v);
        @(negedge clk);
        mask_wdata = v;
        if (which_irq) imask_we = 1'b1; else rmask_we = 1'b1;
        @(negedge clk);
        imask_we = 1'b0; rmask_we = 1'b0;
        if (which_irq) m_imask = v; else m_rmask = v;
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        m_rmask = 8'hFF; m_imask = 8'h00; m_lat = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rt_status", rt_status, 8'h3F);
        chk("R10 lat_status", lat_status, 8'h00);
        chk("R10 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R10 rst_out_n", {7'b0, rst_out_n}, 8'h01);

        // R1 latency: change visible after exactly two edges
        pg_in = 6'h3E;
        @(posedge clk); #1;
        chk("R1 one edge", rt_status, 8'h3F);
        @(posedge clk); #1;
        chk("R1 two edges", rt_status, 8'h3E);
        settle();
        m_lat = 8'h01;
        // R6 default reset mask, R8 default interrupt mask
        chk("R6 default rmask", {7'b0, rst_out_n}, 8'h00);
        chk("R8 default imask", {7'b0, irq_n}, 8'h01);
        chk("R2 pg0 lost", lat_status, 8'h01);

        // R3 fault leaves, latch holds, reset releases
        apply(6'h3F, 1'b0, 1'b0);
        chk("R3 sticky", lat_status, 8'h01);
        chk("R5 release", {7'b0, rst_out_n}, 8'h01);

        // R2 uv and ot positions
        apply(6'h3F, 1'b1, 1'b0);
        chk("R2 uv bit7", lat_status, 8'h81);
        apply(6'h3F, 1'b0, 1'b1);
        chk("R2 ot bit6", lat_status, 8'hC1);

        // R9 interrupt mask routes ot only
        write_mask(1'b1, 8'h40);
        settle();
        chk("R9 imask load", {7'b0, irq_n}, 8'h00);
        // R9 reset mask excluding ot
        apply(6'h3F, 1'b0, 1'b1);
        write_mask(1'b0, 8'hBF);
        settle();
        chk("R9 rmask load", {7'b0, rst_out_n}, 8'h01);

        // R4 clear with ot still present: zero then re-latch
        do_clear();
        chk("R4 cleared", lat_status, 8'h00);
        chk("R7 released", {7'b0, irq_n}, 8'h01);
        @(negedge clk);
        chk("R4 relatch", lat_status, 8'h40);
        settle();
        chk("R7 relatch irq", {7'b0, irq_n}, 8'h00);
        m_lat = 8'h40;

        // R4 clear with no fault present stays empty
        apply(6'h3F, 1'b0, 1'b0);
        do_clear();
        m_lat = 8'h00;
        settle();
        check_all("R4 idle clear");

        // random stimulus
        void'($urandom(seed));
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'h0) write_mask(1'b1, 8'($urandom));
            if (r[7:4] == 4'h0) write_mask(1'b0, 8'($urandom));
            apply((r[8] ? 6'($urandom) : 6'h3F), r[9] & r[10], r[11] & r[12]);
            check_all("rand");
            if (r[15:13] == 3'd0) begin
                do_clear();
                settle();
                m_lat = fault_of(pg_in, uv_in, ot_in);
                check_all("R4 rand clear");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule